// File: doc/BRIEF.md
# OTN Section Monitor Overhead Inserter

This block fills in the three section-monitoring overhead bytes of each outgoing OTUk frame on a byte-wide stream. Surrounding framing logic marks the start of every frame, supplies the low six bits of the multiframe counter, flags which bytes belong to the OPUk payload, and points at the three overhead slots. The block passes every other byte through unchanged and puts its own value into the slots, with a fixed latency of one clock.

A 2-bit mode chooses where each subfield comes from. The generated source builds the trail trace byte from a 32-word by 16-bit register array, indexed by the multiframe count. It also builds a BIP-8 parity byte over the payload of the frame two frames earlier, and a status byte. The status byte carries the backward error count, a backward defect bit derived from selectable far-path signal-fail inputs, an incoming alignment error flag and two reserved bits. The other sources are an external overhead input port and the overhead taken from the received stream. The hold timer for the alignment error flag sits outside this block, and the flag arrives already formed.

Top module: `smOhInserter`

## Requirements
- R1: When `ohPos` is 0 (no slot), `dataOut` equals the `dataIn` of the previous cycle, and `frameStartOut` always equals `frameStart` delayed by one cycle. `ohPos` encoding: 0 none, 1 trail trace slot, 2 parity slot, 3 status slot. Slots never coincide with `frameStart`.
- R2: In modes 00 and 10, the trail trace slot carries byte n = MFAS[5:0] of the frame, latched at `frameStart`. Word n/2 of the array supplies it: bits 15:8 when n is even and bits 7:0 when n is odd. A word is written when `ttiWe` is high, at address `ttiAddr`.
- R3: In modes 00, 01 and 10, the parity slot of frame i+2 carries the XOR of all `dataIn` bytes with `opuValid` high in frame i. Frame i runs from its `frameStart` cycle (inclusive) to the next `frameStart` cycle (exclusive).
- R4: Reset clears the parity pipeline and `dataOut`. Payload bytes before the first `frameStart` after reset are not counted, so the first two frames after reset carry parity 0x00.
- R5: The generated status byte is laid out as BEI in bits 7:4, BDI in bit 3, IAE in bit 2 and the reserved bits in bits 1:0.
- R6: In modes 00 and 10, BEI equals `beiIn` and IAE equals `iaeIn`. BDI = (`sfSel[0]` & `losIn`) | (`sfSel[1]` & `lofIn`).
- R7: In mode 01, the trail trace slot carries `extSm[23:16]` and status bits 7:2 carry `extSm[7:2]`. Parity is still generated internally, as in R3.
- R8: In mode 11, the three slots carry `rxSm[23:16]`, `rxSm[15:8]` and `rxSm[7:0]` in that order.
- R9: In modes 00, 01 and 10, the reserved bits are 00 when `extPresent` is low. When it is high, they come from `rxSm[1:0]` in modes 00 and 10 and from `extSm[1:0]` in mode 01.
- R10: Mode 10 behaves exactly like mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | First byte of a frame |
| mfasIn | input | 6 | Low six bits of MFAS, valid with frameStart |
| opuValid | input | 1 | Current byte is OPUk payload |
| ohPos | input | 2 | Overhead slot marker (0 none, 1 trace, 2 parity, 3 status) |
| dataIn | input | 8 | Incoming frame byte |
| mode | input | 2 | Subfield source mode |
| ttiWe | input | 1 | Trail trace array write strobe |
| ttiAddr | input | 5 | Trail trace array word address |
| ttiData | input | 16 | Trail trace array write word |
| extPresent | input | 1 | External overhead source present |
| extSm | input | 24 | External section monitor bytes (trace, parity, status) |
| rxSm | input | 24 | Received section monitor bytes (trace, parity, status) |
| losIn | input | 1 | Far-path loss of signal |
| lofIn | input | 1 | Far-path loss of frame |
| sfSel | input | 2 | Signal-fail select (bit0 LOS, bit1 LOF) |
| beiIn | input | 4 | Backward error count from the overhead monitor |
| iaeIn | input | 1 | Alignment error flag, already held |
| dataOut | output | 8 | Outgoing frame byte, one cycle latency |
| frameStartOut | output | 1 | frameStart aligned to dataOut |

## Verification
The bench goes after the two-frame parity delay. A pipeline one stage short would put the parity of frame i+1 into the slot, and one stage long would put in the parity of frame i-1. It also resets the block in mid-stream with payload bytes already flowing, so an accumulator that counted bytes before the first frame start would leave non-zero parity in the first frames. It runs the trace array across more than a full 64-frame multiframe and then through mode 10, which catches a swapped high/low byte or an index taken from the wrong MFAS bits. With random `sfSel`, `extPresent` and side inputs on every cycle, any mode or source mix-up, or any reserved bit that leaks when no external source is present, shows up at once in the compared bytes.

// File: rtl/smOhPkg.sv
package smOhPkg;
  localparam int BYTE_W     = 8;
  localparam int MFAS_IDX_W = 6;
  localparam int BEI_W      = 4;
  localparam int RES_W      = 2;
  localparam int SM_W       = 3 * BYTE_W;

  typedef enum logic [1:0] {
    POS_NONE = 2'd0,
    POS_TTI  = 2'd1,
    POS_BIP  = 2'd2,
    POS_STAT = 2'd3
  } ohPosE;

  typedef enum logic [1:0] {
    SRC_GEN = 2'd0,
    SRC_EXT = 2'd1,
    SRC_RX  = 2'd2
  } srcSelE;

  typedef struct packed {
    logic   frameRoll;
    logic   accEn;
    logic   selTti;
    logic   selBip;
    logic   selStat;
    srcSelE src;
  } smStrobeT;
endpackage

// File: rtl/smOhCtrl.sv
module smOhCtrl
  import smOhPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameStart,
  input  logic [MFAS_IDX_W-1:0] mfasIn,
  input  logic                  opuValid,
  input  logic [1:0]            ohPos,
  input  logic [1:0]            mode,
  output smStrobeT              strb,
  output logic [MFAS_IDX_W-1:0] ttiIdx
);
  logic                  seenStart;
  logic [MFAS_IDX_W-1:0] mfasReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenStart <= 1'b0;
      mfasReg   <= '0;
    end else if (frameStart) begin
      seenStart <= 1'b1;
      mfasReg   <= mfasIn;
    end
  end

  always_comb begin
    strb.frameRoll = frameStart;
    strb.accEn     = opuValid & (seenStart | frameStart);
    strb.selTti    = (ohPos == POS_TTI);
    strb.selBip    = (ohPos == POS_BIP);
    strb.selStat   = (ohPos == POS_STAT);
    unique case (mode)
      2'b01:   strb.src = SRC_EXT;
      2'b11:   strb.src = SRC_RX;
      default: strb.src = SRC_GEN;   // 00 and the reserved 10
    endcase
    ttiIdx = frameStart ? mfasIn : mfasReg;
  end

  // R2: index held through the frame equals the MFAS seen at its start
  a_r2_idx_latched: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (frameStart || ttiIdx == $past(mfasIn)));
endmodule

// File: rtl/smTtiStore.sv
module smTtiStore #(
  parameter int WORDS  = 32,
  parameter int WORD_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              we,
  input  logic [$clog2(WORDS)-1:0]          wAddr,
  input  logic [WORD_W-1:0]                 wData,
  input  logic [$clog2(WORDS)+$clog2(WORD_W/8)-1:0] rdIdx,
  output logic [7:0]                        rdByte
);
  localparam int ADDR_W  = $clog2(WORDS);
  localparam int BPW     = WORD_W / 8;
  localparam int SEL_W   = $clog2(BPW);
  localparam int IDX_W   = ADDR_W + SEL_W;

  logic [WORD_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        words[w] <= '0;
      else if (we && wAddr == ADDR_W'(w))
        words[w] <= wData;
    end
  end

  logic [WORD_W-1:0] curWord;
  logic [SEL_W-1:0]  byteNum;

  always_comb begin
    curWord = words[rdIdx[IDX_W-1:SEL_W]];
    byteNum = rdIdx[SEL_W-1:0];
    // byte 0 of a word is its most significant byte
    rdByte  = curWord[WORD_W-1-8*int'(byteNum) -: 8];
  end
endmodule

// File: rtl/smOhDatapath.sv
module smOhDatapath
  import smOhPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  smStrobeT          strb,
  input  logic              frameStart,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic [BYTE_W-1:0] ttiByte,
  input  logic              extPresent,
  input  logic [SM_W-1:0]   extSm,
  input  logic [SM_W-1:0]   rxSm,
  input  logic              losIn,
  input  logic              lofIn,
  input  logic [1:0]        sfSel,
  input  logic [BEI_W-1:0]  beiIn,
  input  logic              iaeIn,
  output logic [BYTE_W-1:0] dataOut,
  output logic              frameStartOut
);
  localparam int SF_SRC = 2;

  logic [BYTE_W-1:0] acc;      // running parity of the current frame
  logic [BYTE_W-1:0] bipNew;   // parity of the previous frame
  logic [BYTE_W-1:0] bipOld;   // parity of two frames back, inserted now
  logic [1:0]        framesSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      bipNew <= '0;
      bipOld <= '0;
    end else if (strb.frameRoll) begin
      bipOld <= bipNew;
      bipNew <= acc;
      acc    <= strb.accEn ? dataIn : '0;
    end else if (strb.accEn) begin
      acc    <= acc ^ dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      framesSeen <= '0;
    else if (strb.frameRoll && framesSeen != 2'd3)
      framesSeen <= framesSeen + 2'd1;
  end

  // signal-fail select, one enable per source
  logic [SF_SRC-1:0] sfVec;
  logic [SF_SRC-1:0] sfHit;
  assign sfVec = {lofIn, losIn};
  for (genvar s = 0; s < SF_SRC; s++) begin : gSf
    assign sfHit[s] = sfVec[s] & sfSel[s];
  end

  logic              bdiGen;
  logic [RES_W-1:0]  resvGen;
  logic [RES_W-1:0]  resvExt;
  logic [BYTE_W-1:0] statGen;
  logic [BYTE_W-1:0] statExt;
  logic [BYTE_W-1:0] ttiOut;
  logic [BYTE_W-1:0] bipOut;
  logic [BYTE_W-1:0] statOut;
  logic [BYTE_W-1:0] nextOut;

  always_comb begin
    bdiGen  = |sfHit;
    resvGen = extPresent ? rxSm[RES_W-1:0] : '0;
    resvExt = extPresent ? extSm[RES_W-1:0] : '0;
    statGen = {beiIn, bdiGen, iaeIn, resvGen};
    statExt = {extSm[BYTE_W-1:RES_W], resvExt};

    unique case (strb.src)
      SRC_EXT: begin
        ttiOut  = extSm[3*BYTE_W-1:2*BYTE_W];
        bipOut  = bipOld;
        statOut = statExt;
      end
      SRC_RX: begin
        ttiOut  = rxSm[3*BYTE_W-1:2*BYTE_W];
        bipOut  = rxSm[2*BYTE_W-1:BYTE_W];
        statOut = rxSm[BYTE_W-1:0];
      end
      default: begin
        ttiOut  = ttiByte;
        bipOut  = bipOld;
        statOut = statGen;
      end
    endcase

    if (strb.selTti)       nextOut = ttiOut;
    else if (strb.selBip)  nextOut = bipOut;
    else if (strb.selStat) nextOut = statOut;
    else                   nextOut = dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut       <= '0;
      frameStartOut <= 1'b0;
    end else begin
      dataOut       <= nextOut;
      frameStartOut <= frameStart;
    end
  end

  // R4: frames 0 and 1 after reset carry zero parity
  a_r4_bip_zero_early: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selBip && strb.src != SRC_RX && framesSeen != 2'd3) |=> dataOut == '0);

  // R3: parity slot shows the value two stages down the pipeline
  a_r3_bip_from_pipe: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selBip && strb.src != SRC_RX) |=> dataOut == $past(bipOld));
endmodule

// File: rtl/smOhInserter.sv
module smOhInserter
  import smOhPkg::*;
#(
  parameter int TTI_WORDS  = 32,
  parameter int TTI_WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic [5:0]  mfasIn,
  input  logic        opuValid,
  input  logic [1:0]  ohPos,
  input  logic [7:0]  dataIn,
  input  logic [1:0]  mode,
  input  logic        ttiWe,
  input  logic [4:0]  ttiAddr,
  input  logic [15:0] ttiData,
  input  logic        extPresent,
  input  logic [23:0] extSm,
  input  logic [23:0] rxSm,
  input  logic        losIn,
  input  logic        lofIn,
  input  logic [1:0]  sfSel,
  input  logic [3:0]  beiIn,
  input  logic        iaeIn,
  output logic [7:0]  dataOut,
  output logic        frameStartOut
);
  smStrobeT              strb;
  logic [MFAS_IDX_W-1:0] ttiIdx;
  logic [BYTE_W-1:0]     ttiByte;

  smOhCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .mfasIn     (mfasIn),
    .opuValid   (opuValid),
    .ohPos      (ohPos),
    .mode       (mode),
    .strb       (strb),
    .ttiIdx     (ttiIdx)
  );

  smTtiStore #(.WORDS(TTI_WORDS), .WORD_W(TTI_WORD_W)) tti_i (
    .clk    (clk),
    .rstN   (rstN),
    .we     (ttiWe),
    .wAddr  (ttiAddr),
    .wData  (ttiData),
    .rdIdx  (ttiIdx),
    .rdByte (ttiByte)
  );

  smOhDatapath dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .frameStart    (frameStart),
    .dataIn        (dataIn),
    .ttiByte       (ttiByte),
    .extPresent    (extPresent),
    .extSm         (extSm),
    .rxSm          (rxSm),
    .losIn         (losIn),
    .lofIn         (lofIn),
    .sfSel         (sfSel),
    .beiIn         (beiIn),
    .iaeIn         (iaeIn),
    .dataOut       (dataOut),
    .frameStartOut (frameStartOut)
  );

  // R1: bytes outside the slots pass through with one cycle latency
  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (ohPos == 2'd0) |=> dataOut == $past(dataIn));

  // R7: external trace byte in mode 01
  a_r7_ext_trace: assert property (@(posedge clk) disable iff (!rstN)
    (ohPos == 2'd1 && mode == 2'b01) |=> dataOut == $past(extSm[23:16]));

  // R8: received parity byte in mode 11
  a_r8_rx_parity: assert property (@(posedge clk) disable iff (!rstN)
    (ohPos == 2'd2 && mode == 2'b11) |=> dataOut == $past(rxSm[15:8]));

  // R9: reserved bits are zero with no external source
  a_r9_resv_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ohPos == 2'd3 && mode != 2'b11 && !extPresent) |=> dataOut[1:0] == 2'b00);
endmodule

// File: tb/smOhInserter_tb_top.sv
module smOhInserter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [5:0]  mfasIn = '0;
  logic        opuValid = 1'b0;
  logic [1:0]  ohPos = '0;
  logic [7:0]  dataIn = '0;
  logic [1:0]  mode = '0;
  logic        ttiWe = 1'b0;
  logic [4:0]  ttiAddr = '0;
  logic [15:0] ttiData = '0;
  logic        extPresent = 1'b0;
  logic [23:0] extSm = '0;
  logic [23:0] rxSm = '0;
  logic        losIn = 1'b0;
  logic        lofIn = 1'b0;
  logic [1:0]  sfSel = '0;
  logic [3:0]  beiIn = '0;
  logic        iaeIn = 1'b0;
  logic [7:0]  dataOut;
  logic        frameStartOut;

  always #4 clk = ~clk;   // 125 MHz

  smOhInserter dut_i (.*);

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  // reference model state
  int         frameIdx;
  logic [7:0] accM;
  logic [7:0] parHist[$];
  logic [15:0] ttiM [32];
  logic [5:0] mfasM;

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic modelReset();
    frameIdx = -1;
    accM = '0;
    parHist.delete();
    mfasM = '0;
    for (int i = 0; i < 32; i++) ttiM[i] = '0;
  endtask

  // one clock: predict, clock, update model, compare
  task automatic stepCycle();
    logic [7:0] exp;
    logic [5:0] idx;
    logic [15:0] w;
    logic [1:0] resv;
    logic bdi;
    string tag;
    bit gen;
    gen = (mode == 2'b00 || mode == 2'b10);
    idx = frameStart ? mfasIn : mfasM;
    w = ttiM[idx[5:1]];
    bdi = (sfSel[0] & losIn) | (sfSel[1] & lofIn);
    case (ohPos)
      2'd0: begin exp = dataIn; tag = "R1 pass-through"; end
      2'd1: begin
        if (mode == 2'b11)      begin exp = rxSm[23:16]; tag = "R8 rx trace"; end
        else if (mode == 2'b01) begin exp = extSm[23:16]; tag = "R7 ext trace"; end
        else begin
          exp = idx[0] ? w[7:0] : w[15:8];
          tag = (mode == 2'b10) ? "R10 trace in mode 10" : "R2 trace byte";
        end
      end
      2'd2: begin
        if (mode == 2'b11) begin exp = rxSm[15:8]; tag = "R8 rx parity"; end
        else if (frameIdx < 2) begin exp = 8'h00; tag = "R4 early parity"; end
        else begin exp = parHist[frameIdx-2]; tag = "R3 parity i+2"; end
      end
      default: begin
        if (mode == 2'b11) begin exp = rxSm[7:0]; tag = "R8 rx status"; end
        else if (mode == 2'b01) begin
          resv = extPresent ? extSm[1:0] : 2'b00;
          exp = {extSm[7:2], resv};
          tag = extPresent ? "R7 ext status" : "R9 reserved zero";
        end else begin
          resv = extPresent ? rxSm[1:0] : 2'b00;
          exp = {beiIn, bdi, iaeIn, resv};
          tag = extPresent ? "R5 R6 status layout" : "R9 reserved zero";
        end
      end
    endcase
    if (!gen && ohPos == 2'd0) tag = "R1 pass-through";
    @(posedge clk);
    // model update at the edge
    if (ttiWe) ttiM[ttiAddr] = ttiData;
    if (frameStart) begin
      if (frameIdx >= 0) parHist.push_back(accM);
      frameIdx++;
      mfasM = mfasIn;
      accM = opuValid ? dataIn : 8'h00;
    end else if (opuValid && frameIdx >= 0) begin
      accM = accM ^ dataIn;
    end
    #2;
    check(dataOut, exp, tag);
    check({7'd0, frameStartOut}, {7'd0, frameStart}, "R1 frame start delay");
  endtask

  task automatic randSide();
    extPresent = 1'($urandom);
    extSm = 24'($urandom);
    rxSm  = 24'($urandom);
    losIn = 1'($urandom);
    lofIn = 1'($urandom);
    sfSel = 2'($urandom);
    beiIn = 4'($urandom);
    iaeIn = 1'($urandom);
    dataIn = 8'($urandom);
  endtask

  task automatic sendFrame(input logic [5:0] mf);
    for (int b = 0; b < 16; b++) begin
      randSide();
      frameStart = (b == 0);
      mfasIn = (b == 0) ? mf : 6'($urandom);
      ohPos = (b >= 1 && b <= 3) ? 2'(b) : 2'd0;
      opuValid = (b >= 4);
      stepCycle();
    end
    frameStart = 1'b0;
    opuValid = 1'b0;
    ohPos = 2'd0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    frameStart = 1'b0; opuValid = 1'b0; ohPos = 2'd0; ttiWe = 1'b0;
    modelReset();
    repeat (3) @(posedge clk);
    #2;
    check(dataOut, 8'h00, "R4 reset output");
    check({7'd0, frameStartOut}, 8'h00, "R1 reset frame start");
    @(negedge clk);
    rstN = 1'b1;
    #2;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog R1-wide: actual %0d cycles expected under 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [5:0] mf;
    modelReset();
    doReset();

    // load the trace array (R2)
    for (int i = 0; i < 32; i++) begin
      randSide();
      ttiWe = 1'b1;
      ttiAddr = 5'(i);
      ttiData = {8'(i * 7 + 3), 8'(i * 13 + 8'h55)};
      stepCycle();
    end
    ttiWe = 1'b0;

    mf = 6'd0;
    mode = 2'b00;                       // R2 R3 R4 R5 R6 R9
    for (int f = 0; f < 70; f++) begin sendFrame(mf); mf = mf + 6'd1; end
    mode = 2'b10;                       // R10
    for (int f = 0; f < 66; f++) begin sendFrame(mf); mf = mf + 6'd1; end
    mode = 2'b01;                       // R7 R9 R3
    for (int f = 0; f < 24; f++) begin sendFrame(mf); mf = mf + 6'd1; end
    mode = 2'b11;                       // R8
    for (int f = 0; f < 24; f++) begin sendFrame(mf); mf = mf + 6'd1; end
    mode = 2'b00;
    for (int f = 0; f < 8; f++) begin sendFrame(mf); mf = mf + 6'd1; end

    // mid-stream reset with payload before the first frame start (R4)
    doReset();
    for (int i = 0; i < 32; i++) begin
      randSide();
      ttiWe = 1'b1;
      ttiAddr = 5'(i);
      ttiData = 16'($urandom);
      stepCycle();
    end
    ttiWe = 1'b0;
    for (int i = 0; i < 9; i++) begin
      randSide();
      opuValid = 1'b1;
      stepCycle();
    end
    opuValid = 1'b0;
    mf = 6'd37;
    for (int f = 0; f < 12; f++) begin sendFrame(mf); mf = mf + 6'd1; end
    mode = 2'b01;
    for (int f = 0; f < 4; f++) begin sendFrame(mf); mf = mf + 6'd1; end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule